// File: doc/BRIEF.md
# Byte-Window GPIO Port for a Software-Driven Two-Wire Bus

This block is a tiny general-purpose I/O port whose output and direction bits drive the two lines of an I2C/SMBus bus directly. Software toggles the data and clock lines one access at a time and reads the sensed data level back. The block has no protocol engine. Each line is open-drain, so the block only ever decides whether to pull the line low. The data line is sensed through a two-flop synchroniser.

The register window is four bytes wide and is reached through byte-wide reads and writes on an I/O address bus. The window is placed by a configuration-space write. A base register is loaded first, and an arm command then maps the window at that base plus a fixed offset. The window stays unmapped until the first arm command. Later arm commands move the window to the base that is loaded at that moment.

Top module: `gpio_i2c_port`

## Requirements
- R1: After reset the direction byte reads 0x00, the output byte reads 0xFF, the input byte reads 0x00, neither line is pulled low (sda_oe = 0, scl_oe = 0), and the window is unmapped.
- R2: A configuration write to offset 0x40 loads a 16-bit base from cfg_wdata[15:0]. A configuration write to offset 0x44 whose data is exactly 0x11 maps the window at base + 0x38. Any other data written to offset 0x44 changes nothing. Loading a new base does not move a window that is already mapped until the next arm command.
- R3: io_hit is 1 only while a read or write is requested and the address lies in the 4 bytes starting at the window address. io_rdata is 0x00 whenever no read is claimed.
- R4: A claimed read returns the byte selected by the address minus the window address: 0 is the input byte, 1 the output byte, 2 the direction byte, and 3 always reads 0x00.
- R5: Writes to byte 0 (input) and byte 3 (unused) change nothing.
- R6: A write whose data equals the byte currently held in its lane has no effect at all, including on the input byte.
- R7: sda_oe is 1 exactly when direction bit 0 is 1 and output bit 0 is 0.
- R8: After an effective write that leaves direction bit 1 at 1, scl_oe becomes the inverse of output bit 1. In every other case scl_oe keeps its value.
- R9: Every effective write loads the input byte with the synchronised data-line level in bit 0 and zeros in bits 7..1.
- R10: The data-line level captured by a write is the value sda_in had two clock edges before the write edge, so a change made in the write's own cycle is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| io_rd_en | input | 1 | I/O byte read request |
| io_wr_en | input | 1 | I/O byte write request |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | I/O write data |
| io_hit | output | 1 | Access claimed by the window |
| io_rdata | output | 8 | Read data, zero when no read is claimed |
| sda_in | input | 1 | Sensed data-line level |
| sda_oe | output | 1 | Pull data line low |
| scl_oe | output | 1 | Pull clock line low |

## Verification
The bench probes the addresses one byte below and one byte above the window. A decoder with an off-by-one range would claim one of them. It writes an unchanged byte after the data line has moved, and a design that ignores the equality rule would refresh the input byte. It clears the clock direction bit and then rewrites the output, and a design that drives the clock line combinationally from the output bit would release the line. It also flips sda_in in the same cycle as a write and rearms after loading a new base. A missing synchroniser stage, or a window that follows the base register without an arm command, shows up as a wrong input byte or a wrong claim.

// File: rtl/gpio_i2c_pkg.sv
// Shared types and fixed constants for the byte-window GPIO port.
// Assumes a four-lane window with one byte per lane.
package gpio_i2c_pkg;
    localparam int BYTE_W   = 8;
    localparam int LANES    = 4;
    localparam int LANE_AW  = $clog2(LANES);

    typedef enum logic [LANE_AW-1:0] {
        LANE_IN  = 2'd0,
        LANE_OUT = 2'd1,
        LANE_DIR = 2'd2,
        LANE_PAD = 2'd3
    } lane_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2. Reset loads RST_VAL into every stage.
module gpio_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // shift the level one stage further per clock
            always_ff @(posedge clk) begin
                if (!rst_n)      chain_q[i] <= RST_VAL;
                else if (i == 0) chain_q[i] <= d;
                else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_win_dec.sv
// Window placement and address decode.
// The base is loaded from configuration space. An arm command with the
// key value latches base + WIN_OFS as the window address and marks it
// mapped. Assumes only one configuration write per cycle.
module gpio_win_dec
    import gpio_i2c_pkg::*;
#(
    parameter int IO_AW    = 16,
    parameter int CFG_AW   = 8,
    parameter int CFG_DW   = 32,
    parameter int WIN_OFS  = 'h38,
    parameter int BASE_REG = 'h40,
    parameter int MAP_REG  = 'h44,
    parameter int MAP_KEY  = 'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              io_rd_en,
    input  logic              io_wr_en,
    input  logic [IO_AW-1:0]  io_addr,
    output logic              hit,
    output lane_e             lane
);
    localparam logic [IO_AW-1:0] OFS_V = IO_AW'(WIN_OFS);
    localparam logic [IO_AW-1:0] SPAN  = IO_AW'(LANES);

    logic [IO_AW-1:0] base_q;
    logic [IO_AW-1:0] win_q;
    logic             mapped_q;
    logic [IO_AW-1:0] rel;
    logic             base_wr;
    logic             arm_wr;

    assign base_wr = cfg_wr_en && (cfg_addr == CFG_AW'(BASE_REG));
    assign arm_wr  = cfg_wr_en && (cfg_addr == CFG_AW'(MAP_REG))
                     && (cfg_wdata == CFG_DW'(MAP_KEY));

    // hold the programmed base until an arm command uses it
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= cfg_wdata[IO_AW-1:0];
    end

    // latch the window address and mapped flag on an arm command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            mapped_q <= 1'b0;
        end else if (arm_wr) begin
            win_q    <= base_q + OFS_V;
            mapped_q <= 1'b1;
        end
    end

    // claim accesses that land inside the four-byte window
    always_comb begin
        rel  = io_addr - win_q;
        hit  = (io_rd_en || io_wr_en) && mapped_q && (rel < SPAN);
        lane = lane_e'(rel[LANE_AW-1:0]);
    end

    // R2
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == CFG_AW'(MAP_REG) && cfg_wdata != CFG_DW'(MAP_KEY))
        |=> ($stable(win_q) && $stable(mapped_q)));

    // R3
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> mapped_q);
endmodule

// File: rtl/gpio_lane_regs.sv
// Input, output and direction bytes plus the open-drain line controls.
// Writes take effect only on the output and direction lanes, and only
// when the data differs from the held byte. An effective write refreshes
// the input byte from the synchronised data line. The clock-line pull is
// re-evaluated only when the new direction bit 1 is set.
module gpio_lane_regs
    import gpio_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  lane_e             lane,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              sda_sense,
    output logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic              scl_oe
);
    localparam int SDA_BIT = 0;
    localparam int SCL_BIT = 1;

    logic [BYTE_W-1:0] in_q, out_q, dir_q;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] out_nx, dir_nx;
    logic              scl_low_q;
    logic              eff_wr;

    // pick the byte held in the addressed lane
    always_comb begin
        case (lane)
            LANE_IN:  cur_byte = in_q;
            LANE_OUT: cur_byte = out_q;
            LANE_DIR: cur_byte = dir_q;
            default:  cur_byte = '0;
        endcase
    end

    // decide whether the write changes state and form the next bytes
    always_comb begin
        eff_wr = wr_en && (lane == LANE_OUT || lane == LANE_DIR) && (wdata != cur_byte);
        out_nx = (lane == LANE_OUT) ? wdata : out_q;
        dir_nx = (lane == LANE_DIR) ? wdata : dir_q;
    end

    // update the register bytes on an effective write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '1;
            dir_q <= '0;
        end else if (eff_wr) begin
            in_q  <= {{(BYTE_W-1){1'b0}}, sda_sense};
            out_q <= out_nx;
            dir_q <= dir_nx;
        end
    end

    // re-evaluate the clock-line pull only while its direction bit is set
    always_ff @(posedge clk) begin
        if (!rst_n)                         scl_low_q <= 1'b0;
        else if (eff_wr && dir_nx[SCL_BIT]) scl_low_q <= ~out_nx[SCL_BIT];
    end

    // drive the line controls and the read data
    always_comb begin
        sda_oe = dir_q[SDA_BIT] & ~out_q[SDA_BIT];
        scl_oe = scl_low_q;
        rdata  = rd_en ? cur_byte : '0;
    end

    // R5
    ro_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (lane == LANE_IN || lane == LANE_PAD))
        |=> ($stable(in_q) && $stable(out_q) && $stable(dir_q)));

    // R6
    same_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == cur_byte)
        |=> ($stable(in_q) && $stable(out_q) && $stable(dir_q) && $stable(scl_oe)));

    // R8
    scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && lane == LANE_DIR && wdata[SCL_BIT]) && !dir_q[SCL_BIT]
        |=> $stable(scl_oe));

    // R9
    refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_wr |=> (in_q == {{(BYTE_W-1){1'b0}}, $past(sda_sense)}));
endmodule

// File: rtl/gpio_i2c_port.sv
// Top of the byte-window GPIO port that bit-bangs a two-wire bus.
// Assumes the caller presents one byte access per cycle. io_hit and
// io_rdata are combinational from the address and the held state.
module gpio_i2c_port
    import gpio_i2c_pkg::*;
#(
    parameter int IO_AW       = 16,
    parameter int CFG_AW      = 8,
    parameter int CFG_DW      = 32,
    parameter int WIN_OFS     = 'h38,
    parameter int BASE_REG    = 'h40,
    parameter int MAP_REG     = 'h44,
    parameter int MAP_KEY     = 'h11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              io_rd_en,
    input  logic              io_wr_en,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic              io_hit,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              scl_oe
);
    logic  hit;
    lane_e lane;
    logic  sda_sense;

    gpio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_sense)
    );

    gpio_win_dec #(
        .IO_AW(IO_AW), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .WIN_OFS(WIN_OFS),
        .BASE_REG(BASE_REG), .MAP_REG(MAP_REG), .MAP_KEY(MAP_KEY)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .io_rd_en  (io_rd_en),
        .io_wr_en  (io_wr_en),
        .io_addr   (io_addr),
        .hit       (hit),
        .lane      (lane)
    );

    gpio_lane_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hit && io_wr_en),
        .rd_en     (hit && io_rd_en),
        .lane      (lane),
        .wdata     (io_wdata),
        .sda_sense (sda_sense),
        .rdata     (io_rdata),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    assign io_hit = hit;

    // R3
    no_claim_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_hit && io_rd_en) |-> (io_rdata == '0));
endmodule

// File: tb/gpio_i2c_port_test.sv
`timescale 1ns/1ps
module gpio_i2c_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        io_rd_en = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_hit;
    logic [7:0]  io_rdata;
    logic        sda_in = 1'b1;
    logic        sda_oe;
    logic        scl_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_i2c_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .io_rd_en(io_rd_en), .io_wr_en(io_wr_en),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_hit(io_hit),
        .io_rdata(io_rdata), .sda_in(sda_in), .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    // behavioural reference state
    int m_base, m_win, m_in, m_out, m_dir;
    bit m_mapped, m_scl, m_live;
    int sda_hist[$] = '{1, 1};

    function automatic bit m_claim();
        int rel;
        rel = (io_addr - m_win) & 'hFFFF;
        return (io_rd_en || io_wr_en) && m_mapped && rel < 4;
    endfunction

    function automatic int m_lane_val(int ln);
        case (ln)
            0: return m_in;
            1: return m_out;
            2: return m_dir;
            default: return 0;
        endcase
    endfunction

    function automatic int m_read();
        if (!(m_claim() && io_rd_en)) return 0;
        return m_lane_val((io_addr - m_win) & 3);
    endfunction

    always @(posedge clk) begin
        int sensed;
        int ln;
        sensed = sda_hist[sda_hist.size()-2];
        if (!rst_n) begin
            m_base = 0; m_win = 0; m_mapped = 0;
            m_in = 0; m_out = 'hFF; m_dir = 0; m_scl = 0; m_live = 1;
        end else begin
            if (io_wr_en && m_claim()) begin
                ln = (io_addr - m_win) & 3;
                if ((ln == 1 || ln == 2) && io_wdata != m_lane_val(ln)) begin
                    if (ln == 1) m_out = io_wdata; else m_dir = io_wdata;
                    m_in = sensed;
                    if (m_dir[1]) m_scl = !m_out[1];
                end
            end
            if (cfg_wr_en && cfg_addr == 8'h40) m_base = cfg_wdata & 'hFFFF;
            if (cfg_wr_en && cfg_addr == 8'h44 && cfg_wdata == 32'h11) begin
                m_win = (m_base + 'h38) & 'hFFFF;
                m_mapped = 1;
            end
        end
        sda_hist.push_back(rst_n ? int'(sda_in) : 1);
        if (sda_hist.size() > 4) void'(sda_hist.pop_front());
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every cycle against the model, away from the clock edge
    always @(negedge clk) begin
        #2;
        if (rst_n && m_live && !done) begin
            chk("R3 io_hit per-cycle", int'(io_hit), int'(m_claim()));
            chk("R4 io_rdata per-cycle", int'(io_rdata), m_read());
            chk("R7 sda_oe per-cycle", int'(sda_oe), int'(m_dir[0] && !m_out[0]));
            chk("R8 scl_oe per-cycle", int'(scl_oe), int'(m_scl));
        end
    end

    task automatic cfg_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr_en = 0;
    endtask

    task automatic io_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); io_wr_en = 1; io_addr = a; io_wdata = d;
        @(negedge clk); io_wr_en = 0;
    endtask

    task automatic io_rd(logic [15:0] a, int exp_hit, int exp_d, string tag);
        @(negedge clk); io_rd_en = 1; io_addr = a;
        #1;
        chk({tag, " hit"}, int'(io_hit), exp_hit);
        chk({tag, " data"}, int'(io_rdata), exp_d);
        @(negedge clk); io_rd_en = 0;
    endtask

    task automatic pins(int exp_sda, int exp_scl, string tag);
        @(negedge clk); #1;
        chk({tag, " sda_oe"}, int'(sda_oe), exp_sda);
        chk({tag, " scl_oe"}, int'(scl_oe), exp_scl);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        pins(0, 0, "R1 reset pins");
        io_rd('h0138, 0, 0, "R1 unmapped after reset");
        // R2 base alone and wrong key do not map
        cfg_wr(8'h40, 32'h0100);
        io_rd('h0138, 0, 0, "R2 base without arm");
        cfg_wr(8'h44, 32'h10);
        io_rd('h0138, 0, 0, "R2 wrong key");
        cfg_wr(8'h44, 32'h11);
        io_rd('h0138, 1, 8'h00, "R1 input byte");
        io_rd('h0139, 1, 8'hFF, "R1 output byte");
        io_rd('h013A, 1, 8'h00, "R1 direction byte");
        io_rd('h013B, 1, 8'h00, "R4 unused lane");
        // R3 edges of the window
        io_rd('h0137, 0, 0, "R3 below window");
        io_rd('h013C, 0, 0, "R3 above window");
        // R5 read-only lanes
        io_wr('h0138, 8'h55);
        io_rd('h0138, 1, 8'h00, "R5 input lane write");
        io_wr('h013B, 8'hAA);
        io_rd('h013B, 1, 8'h00, "R5 unused lane write");
        // R9 refresh with data line high, R7 data pull
        io_wr('h013A, 8'h01);
        io_rd('h0138, 1, 8'h01, "R9 refresh high");
        pins(0, 0, "R7 dir set out high");
        io_wr('h0139, 8'hFE);
        pins(1, 0, "R7 dir set out low");
        // R6 unchanged write does not refresh
        sda_in = 0;
        repeat (4) @(negedge clk);
        io_wr('h0139, 8'hFE);
        io_rd('h0138, 1, 8'h01, "R6 same data write");
        io_wr('h0139, 8'hFC);
        io_rd('h0138, 1, 8'h00, "R9 refresh low");
        pins(1, 0, "R8 clock dir clear");
        // R8 clock line follows only with its direction bit set
        io_wr('h013A, 8'h03);
        pins(1, 1, "R8 clock dir set");
        io_wr('h013A, 8'h01);
        io_wr('h0139, 8'hFF);
        pins(0, 1, "R8 clock held");
        // R10 change in the write cycle is not seen
        @(negedge clk); sda_in = 1; io_wr_en = 1; io_addr = 'h013A; io_wdata = 8'h02;
        @(negedge clk); io_wr_en = 0;
        io_rd('h0138, 1, 8'h00, "R10 late change");
        pins(0, 0, "R8 clock released");
        repeat (3) @(negedge clk);
        io_wr('h013A, 8'h00);
        io_rd('h0138, 1, 8'h01, "R10 settled change");
        // R2 remap only on arm
        cfg_wr(8'h40, 32'h2000);
        io_rd('h0138, 1, 8'h01, "R2 old window kept");
        cfg_wr(8'h44, 32'h11);
        io_rd('h2039, 1, 8'hFF, "R2 new window");
        io_rd('h0138, 0, 0, "R2 old window gone");
        // R3 no request, no claim
        @(negedge clk); io_addr = 'h2038; #1;
        chk("R3 idle address", int'(io_hit), 0);
        chk("R3 idle rdata", int'(io_rdata), 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule